// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block is the system control coprocessor that sits beside a processor pipeline. The pipeline reaches it through a single register-transfer command port. Each command carries a read/write flag, a 4-bit register number, the secondary register field CRm, a 3-bit opcode2 and 32 bits of write data. The block stores the memory-management and cache control state: the control word, the translation table base, the domain access permissions, the fault status, the fault address and the process identifier. It presents that state as plain outputs to the memory system.

Writes to the cache-maintenance register (7) and the TLB-maintenance register (8) change no stored register. They are decoded into a set of maintenance operations, which are handed to the memory system under a request/done handshake. The command port stays blocked until the memory system signals done. Encodings that are not recognised run the most thorough whole-system operation instead of being dropped.

When the memory system reports an abort, a fault strobe loads the status and address registers directly. Several control-register bits are hardwired and always read back the same fixed values.

Top module: `sysctl_cop`

## Requirements
- R1: After reset `cmdReady` is 1, `maintReq` is 0, `mmuEn`, `dcacheEn` and `icacheEn` are 0, and `ttb`, `domainAccess` and `pid` are 0. Register 1 then reads 32'h0000_4878.
- R2: Register 1 bit 0 drives `mmuEn`, bit 2 drives `dcacheEn` and bit 12 drives `icacheEn`. Bits 8 and 9 are stored and read back as written. All five bits are writable.
- R3: Register 1 always reads 1 in bits 3, 4, 5, 6, 11 and 14. Every other bit that is not writable reads 0, whatever was written, so writing all ones reads back 32'h0000_5B7D.
- R4: Register 2 stores all 32 written bits, reads them back and drives them on `ttb`.
- R5: Register 3 stores 16 two-bit domain fields, domain X in bits 2X+1:2X. It reads back as written and drives `domainAccess` with the same bit positions.
- R6: Register 13 keeps written bits 31:25 as the process ID, driven on `pid`. Bits 24:0 read 0.
- R7: Register 0 reads the `ID_VALUE` constant, and writes to it have no effect.
- R8: A write to register 7 with opcode2 = 0 sets `maintOps`, whose bit encoding is bit5 flush I-cache, bit4 flush D-cache, bit3 clean I-cache, bit2 clean D-cache, bit1 invalidate I-TLB, bit0 invalidate D-TLB. The CRm values map as follows: 0111 to 6'h30, 0101 to 6'h20, 0110 to 6'h10, 1011 to 6'h0C, 1010 to 6'h04, 1111 to 6'h3C, 1110 to 6'h14.
- R9: A write to register 7 with any other opcode2/CRm combination sets `maintOps` to 6'h3C.
- R10: A write to register 8 with opcode2 = 0 maps CRm 0111 to 6'h03, 0101 to 6'h02 and 0110 to 6'h01. Any other combination gives 6'h03.
- R11: In the cycle after a maintenance write is accepted, `maintReq` rises with `maintOps`, and `cmdReady` goes low. Both stay steady until `maintDone` is sampled high. In the cycle after that, `maintReq` is 0 and `cmdReady` is 1.
- R12: A `faultValid` strobe loads `faultStatus` into register 5 bits 3:0 and `faultAddr` into register 6. It wins over a software write to either register in the same cycle. Register 5 bits 31:4 read 0.
- R13: An accepted read returns its data on `rdData` with `rdValid` high in the following cycle. `rdValid` is 0 in cycles that follow no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present |
| cmdWrite | input | 1 | 1 = register write, 0 = register read |
| cmdReg | input | 4 | Register number |
| cmdCrm | input | 4 | Secondary register field (maintenance selector) |
| cmdOp2 | input | 3 | Opcode2 field |
| cmdWdata | input | 32 | Write data |
| cmdReady | output | 1 | Command accepted when high together with cmdValid |
| rdData | output | 32 | Read data |
| rdValid | output | 1 | rdData holds the result of the previous accepted read |
| maintReq | output | 1 | Maintenance request to the memory system |
| maintOps | output | 6 | Maintenance operation bits (encoding in R8) |
| maintDone | input | 1 | Memory system finished the requested maintenance |
| faultValid | input | 1 | Abort capture strobe |
| faultStatus | input | 4 | Fault status code to capture |
| faultAddr | input | 32 | Faulting address to capture |
| mmuEn | output | 1 | MMU enable |
| dcacheEn | output | 1 | Data cache enable |
| icacheEn | output | 1 | Instruction cache enable |
| ttb | output | 32 | Translation base register contents |
| domainAccess | output | 32 | Domain access fields |
| pid | output | 7 | Process identifier |

## Verification
The bench builds the block with `ID_VALUE` set to a value other than the default, so that an identification readback cannot pass by matching an unconfigured constant. `PID_W` stays at 7 and `NUM_DOMAINS` at 16. With these values the process-ID field covers exactly bits 31:25, and the domain register fills all 32 bits, so the highest domain field at bits 31:30 and the zero-masking of bits 24:0 are both reachable. Every maintenance encoding is exercised, including the fallbacks reached through a non-zero opcode2 and through an unlisted CRm. The bench also drives a fault strobe in the same cycle as a software write to the fault address register.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [3:0] REG_ID    = 4'd0;
  localparam logic [3:0] REG_CTRL  = 4'd1;
  localparam logic [3:0] REG_TTB   = 4'd2;
  localparam logic [3:0] REG_DOM   = 4'd3;
  localparam logic [3:0] REG_FSR   = 4'd5;
  localparam logic [3:0] REG_FAR   = 4'd6;
  localparam logic [3:0] REG_CACHE = 4'd7;
  localparam logic [3:0] REG_TLB   = 4'd8;
  localparam logic [3:0] REG_PID   = 4'd13;

  // Maintenance operation set, MSB first: flushI flushD cleanI cleanD tlbI tlbD
  typedef struct packed {
    logic flushI;
    logic flushD;
    logic cleanI;
    logic cleanD;
    logic tlbI;
    logic tlbD;
  } maintOps_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic        wrEn;
    logic        rdEn;
    logic [3:0]  regSel;
    logic [31:0] wdata;
  } regStrobe_t;

  function automatic maintOps_t decodeMaint(input logic isTlb,
                                            input logic [3:0] crm,
                                            input logic [2:0] op2);
    maintOps_t ops;
    if (isTlb) begin
      ops = maintOps_t'(6'b000011);
      if (op2 == 3'd0) begin
        case (crm)
          4'b0101: ops = maintOps_t'(6'b000010);
          4'b0110: ops = maintOps_t'(6'b000001);
          default: ops = maintOps_t'(6'b000011);
        endcase
      end
    end else begin
      ops = maintOps_t'(6'b111100);
      if (op2 == 3'd0) begin
        case (crm)
          4'b0111: ops = maintOps_t'(6'b110000);
          4'b0101: ops = maintOps_t'(6'b100000);
          4'b0110: ops = maintOps_t'(6'b010000);
          4'b1011: ops = maintOps_t'(6'b001100);
          4'b1010: ops = maintOps_t'(6'b000100);
          4'b1110: ops = maintOps_t'(6'b010100);
          default: ops = maintOps_t'(6'b111100);
        endcase
      end
    end
    return ops;
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdWrite,
  input  logic [3:0]  cmdReg,
  input  logic [3:0]  cmdCrm,
  input  logic [2:0]  cmdOp2,
  input  logic [31:0] cmdWdata,
  output logic        cmdReady,
  input  logic        maintDone,
  output logic        maintReq,
  output maintOps_t   maintOps,
  output regStrobe_t  strobe
);

  logic      busyQ;
  maintOps_t opsQ;
  logic      accept;
  logic      isMaint;

  assign accept  = cmdValid && !busyQ;
  assign isMaint = cmdWrite && ((cmdReg == REG_CACHE) || (cmdReg == REG_TLB));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      opsQ  <= '0;
    end else if (accept && isMaint) begin
      busyQ <= 1'b1;
      opsQ  <= decodeMaint(cmdReg == REG_TLB, cmdCrm, cmdOp2);
    end else if (busyQ && maintDone) begin
      busyQ <= 1'b0;
      opsQ  <= '0;
    end
  end

  always_comb begin
    strobe.wrEn   = accept && cmdWrite && !isMaint;
    strobe.rdEn   = accept && !cmdWrite;
    strobe.regSel = cmdReg;
    strobe.wdata  = cmdWdata;
  end

  assign cmdReady = !busyQ;
  assign maintReq = busyQ;
  assign maintOps = opsQ;

  // R11
  maint_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    maintReq && !maintDone |=> maintReq && $stable(maintOps));

  // R11
  maint_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    maintReq && maintDone |=> !maintReq && cmdReady);

  // R11
  maint_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && cmdWrite && (cmdReg == REG_CACHE) |=> maintReq);

  // R8
  maint_ops_chk: assert property (@(posedge clk) disable iff (!rstN)
    maintReq |-> maintOps != '0);

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE    = 32'h5A00_0001,
  parameter int          PID_W       = 7,
  parameter int          NUM_DOMAINS = 16,
  parameter int          FSR_W       = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrobe_t               strobe,
  input  logic                     faultValid,
  input  logic [FSR_W-1:0]         faultStatus,
  input  logic [31:0]              faultAddr,
  output logic [31:0]              rdData,
  output logic                     rdValid,
  output logic                     mmuEn,
  output logic                     dcacheEn,
  output logic                     icacheEn,
  output logic [31:0]              ttb,
  output logic [2*NUM_DOMAINS-1:0] domainAccess,
  output logic [PID_W-1:0]         pid
);

  localparam int          DOM_W       = 2 * NUM_DOMAINS;
  localparam int          PID_LSB     = 32 - PID_W;
  localparam logic [31:0] CTRL_WR_MSK = 32'h0000_1305;
  localparam logic [31:0] CTRL_ONES   = 32'h0000_4878;

  logic [31:0]      ctrlQ;
  logic [31:0]      ttbQ;
  logic [DOM_W-1:0] domQ;
  logic [FSR_W-1:0] fsrQ;
  logic [31:0]      farQ;
  logic [PID_W-1:0] pidQ;
  logic [31:0]      rdNext;
  logic [31:0]      rdDataQ;
  logic             rdValidQ;
  logic [3:0]       rdSelQ;

  function automatic logic hit(input regStrobe_t s, input logic [3:0] r);
    return s.wrEn && (s.regSel == r);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      ttbQ  <= '0;
      domQ  <= '0;
      pidQ  <= '0;
    end else begin
      if (hit(strobe, REG_CTRL)) ctrlQ <= strobe.wdata & CTRL_WR_MSK;
      if (hit(strobe, REG_TTB))  ttbQ  <= strobe.wdata;
      if (hit(strobe, REG_DOM))  domQ  <= strobe.wdata[DOM_W-1:0];
      if (hit(strobe, REG_PID))  pidQ  <= strobe.wdata[31:PID_LSB];
    end
  end

  // Fault capture has priority over software writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsrQ <= '0;
      farQ <= '0;
    end else if (faultValid) begin
      fsrQ <= faultStatus;
      farQ <= faultAddr;
    end else begin
      if (hit(strobe, REG_FSR)) fsrQ <= strobe.wdata[FSR_W-1:0];
      if (hit(strobe, REG_FAR)) farQ <= strobe.wdata;
    end
  end

  always_comb begin
    case (strobe.regSel)
      REG_ID:   rdNext = ID_VALUE;
      REG_CTRL: rdNext = ctrlQ | CTRL_ONES;
      REG_TTB:  rdNext = ttbQ;
      REG_DOM:  rdNext = 32'(domQ);
      REG_FSR:  rdNext = 32'(fsrQ);
      REG_FAR:  rdNext = farQ;
      REG_PID:  rdNext = {pidQ, {PID_LSB{1'b0}}};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
      rdSelQ   <= '0;
    end else begin
      rdValidQ <= strobe.rdEn;
      if (strobe.rdEn) begin
        rdDataQ <= rdNext;
        rdSelQ  <= strobe.regSel;
      end
    end
  end

  assign rdData       = rdDataQ;
  assign rdValid      = rdValidQ;
  assign mmuEn        = ctrlQ[0];
  assign dcacheEn     = ctrlQ[2];
  assign icacheEn     = ctrlQ[12];
  assign ttb          = ttbQ;
  assign domainAccess = domQ;
  assign pid          = pidQ;

  // R3
  ctrl_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && (rdSelQ == REG_CTRL) |-> (rdData & ~CTRL_WR_MSK) == CTRL_ONES);

  // R12
  fault_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> (farQ == $past(faultAddr)) && (fsrQ == $past(faultStatus)));

  // R6
  pid_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && (rdSelQ == REG_PID) |-> rdData[PID_LSB-1:0] == '0);

  // R7
  id_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && (rdSelQ == REG_ID) |-> rdData == ID_VALUE);

  // R13
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> !rdValid);

endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE    = 32'h5A00_0001,
  parameter int          PID_W       = 7,
  parameter int          NUM_DOMAINS = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic                     cmdWrite,
  input  logic [3:0]               cmdReg,
  input  logic [3:0]               cmdCrm,
  input  logic [2:0]               cmdOp2,
  input  logic [31:0]              cmdWdata,
  output logic                     cmdReady,
  output logic [31:0]              rdData,
  output logic                     rdValid,
  output logic                     maintReq,
  output logic [5:0]               maintOps,
  input  logic                     maintDone,
  input  logic                     faultValid,
  input  logic [3:0]               faultStatus,
  input  logic [31:0]              faultAddr,
  output logic                     mmuEn,
  output logic                     dcacheEn,
  output logic                     icacheEn,
  output logic [31:0]              ttb,
  output logic [2*NUM_DOMAINS-1:0] domainAccess,
  output logic [PID_W-1:0]         pid
);

  regStrobe_t strobe;
  maintOps_t  opsInt;

  sysctl_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdWrite  (cmdWrite),
    .cmdReg    (cmdReg),
    .cmdCrm    (cmdCrm),
    .cmdOp2    (cmdOp2),
    .cmdWdata  (cmdWdata),
    .cmdReady  (cmdReady),
    .maintDone (maintDone),
    .maintReq  (maintReq),
    .maintOps  (opsInt),
    .strobe    (strobe)
  );

  sysctl_regs #(
    .ID_VALUE    (ID_VALUE),
    .PID_W       (PID_W),
    .NUM_DOMAINS (NUM_DOMAINS),
    .FSR_W       (4)
  ) regs_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .faultValid   (faultValid),
    .faultStatus  (faultStatus),
    .faultAddr    (faultAddr),
    .rdData       (rdData),
    .rdValid      (rdValid),
    .mmuEn        (mmuEn),
    .dcacheEn     (dcacheEn),
    .icacheEn     (icacheEn),
    .ttb          (ttb),
    .domainAccess (domainAccess),
    .pid          (pid)
  );

  assign maintOps = opsInt;

endmodule

// File: tb/sysctl_cop_tb_top.sv
module sysctl_cop_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ID_CONST   = 32'h4151_0A7E;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [3:0]  cmdReg = '0;
  logic [3:0]  cmdCrm = '0;
  logic [2:0]  cmdOp2 = '0;
  logic [31:0] cmdWdata = '0;
  logic        cmdReady;
  logic [31:0] rdData;
  logic        rdValid;
  logic        maintReq;
  logic [5:0]  maintOps;
  logic        maintDone = 1'b0;
  logic        faultValid = 1'b0;
  logic [3:0]  faultStatus = '0;
  logic [31:0] faultAddr = '0;
  logic        mmuEn, dcacheEn, icacheEn;
  logic [31:0] ttb;
  logic [31:0] domainAccess;
  logic [6:0]  pid;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_cop #(.ID_VALUE(ID_CONST), .PID_W(7), .NUM_DOMAINS(16)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdReg(cmdReg), .cmdCrm(cmdCrm), .cmdOp2(cmdOp2), .cmdWdata(cmdWdata),
    .cmdReady(cmdReady), .rdData(rdData), .rdValid(rdValid),
    .maintReq(maintReq), .maintOps(maintOps), .maintDone(maintDone),
    .faultValid(faultValid), .faultStatus(faultStatus), .faultAddr(faultAddr),
    .mmuEn(mmuEn), .dcacheEn(dcacheEn), .icacheEn(icacheEn), .ttb(ttb),
    .domainAccess(domainAccess), .pid(pid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R13 unexpected rdValid", rdData, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData === e, t, rdData, e);
      end
    end
  end

  task automatic issue(input bit wr, input logic [3:0] r, input logic [3:0] crm,
                       input logic [2:0] op2, input logic [31:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdWrite = wr; cmdReg = r; cmdCrm = crm; cmdOp2 = op2; cmdWdata = d;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdWrite = 1'b0;
  endtask

  task automatic doWrite(input logic [3:0] r, input logic [31:0] d);
    issue(1'b1, r, 4'd0, 3'd0, d);
  endtask

  task automatic doRead(input logic [3:0] r, input logic [31:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    issue(1'b0, r, 4'd0, 3'd0, 32'h0);
  endtask

  task automatic doMaint(input logic [3:0] r, input logic [3:0] crm, input logic [2:0] op2,
                         input logic [5:0] e, input string tag);
    issue(1'b1, r, crm, op2, 32'h0);
    check(maintReq === 1'b1, {tag, " maintReq raised (R11)"}, 32'(maintReq), 32'h1);
    check(maintOps === e, tag, 32'(maintOps), 32'(e));
    check(cmdReady === 1'b0, "R11 ready low while busy", 32'(cmdReady), 32'h0);
    @(negedge clk);
    check(maintReq === 1'b1 && maintOps === e, "R11 request held", 32'(maintOps), 32'(e));
    maintDone = 1'b1;
    @(negedge clk);
    maintDone = 1'b0;
    check(maintReq === 1'b0 && cmdReady === 1'b1, "R11 release after done",
          {30'h0, maintReq, cmdReady}, 32'h1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmdReady === 1'b1 && maintReq === 1'b0, "R1 handshake idle",
          {30'h0, cmdReady, maintReq}, 32'h2);
    check({mmuEn, dcacheEn, icacheEn} === 3'b000, "R1 enables clear",
          32'({mmuEn, dcacheEn, icacheEn}), 32'h0);
    check(ttb === 0 && domainAccess === 0 && pid === 0, "R1 ttb/dom/pid clear",
          ttb | domainAccess | 32'(pid), 32'h0);
    check(rdValid === 1'b0, "R13 no read pending", 32'(rdValid), 32'h0);
    doRead(4'd1, 32'h0000_4878, "R1 ctrl after reset");
    doRead(4'd13, 32'h0, "R1 pid after reset");

    // R7 identification
    doRead(4'd0, ID_CONST, "R7 id read");
    doWrite(4'd0, 32'hFFFF_FFFF);
    doRead(4'd0, ID_CONST, "R7 id after write");

    // R2 / R3 control register
    doWrite(4'd1, 32'hFFFF_FFFF);
    check({mmuEn, dcacheEn, icacheEn} === 3'b111, "R2 all enables set",
          32'({mmuEn, dcacheEn, icacheEn}), 32'h7);
    check(rdValid === 1'b0, "R13 rdValid low after write", 32'(rdValid), 32'h0);
    doRead(4'd1, 32'h0000_5B7D, "R3 ctrl all ones");
    doWrite(4'd1, 32'h0000_1004);
    check({mmuEn, dcacheEn, icacheEn} === 3'b011, "R2 caches only",
          32'({mmuEn, dcacheEn, icacheEn}), 32'h3);
    doRead(4'd1, 32'h0000_587C, "R2 ctrl caches");
    doWrite(4'd1, 32'h0000_0301);
    check({mmuEn, dcacheEn, icacheEn} === 3'b100, "R2 mmu only",
          32'({mmuEn, dcacheEn, icacheEn}), 32'h4);
    doRead(4'd1, 32'h0000_4B79, "R2 ctrl S/R bits");
    doWrite(4'd1, 32'h0000_0000);
    doRead(4'd1, 32'h0000_4878, "R3 ctrl zero write");

    // R4 translation base
    doWrite(4'd2, 32'hABCD_1234);
    check(ttb === 32'hABCD_1234, "R4 ttb output", ttb, 32'hABCD_1234);
    doRead(4'd2, 32'hABCD_1234, "R4 ttb read");

    // R5 domains
    doWrite(4'd3, 32'hE41B_5A0F);
    check(domainAccess === 32'hE41B_5A0F, "R5 domain output", domainAccess, 32'hE41B_5A0F);
    check(domainAccess[31:30] === 2'b11, "R5 domain 15 field", 32'(domainAccess[31:30]), 32'h3);
    doRead(4'd3, 32'hE41B_5A0F, "R5 domain read");

    // R6 process id
    doWrite(4'd13, 32'hFFFF_FFFF);
    check(pid === 7'h7F, "R6 pid all ones", 32'(pid), 32'h7F);
    doRead(4'd13, 32'hFE00_0000, "R6 pid read masked");
    doWrite(4'd13, 32'h1234_5678);
    check(pid === 7'h09, "R6 pid value", 32'(pid), 32'h09);
    doRead(4'd13, 32'h1200_0000, "R6 pid read");

    // R12 fault capture beats software write
    @(negedge clk);
    faultValid = 1'b1; faultStatus = 4'hD; faultAddr = 32'hDEAD_BEEC;
    cmdValid = 1'b1; cmdWrite = 1'b1; cmdReg = 4'd6; cmdWdata = 32'h1111_1111;
    @(negedge clk);
    faultValid = 1'b0; cmdValid = 1'b0; cmdWrite = 1'b0;
    doRead(4'd6, 32'hDEAD_BEEC, "R12 fault addr wins");
    doRead(4'd5, 32'h0000_000D, "R12 fault status");
    doWrite(4'd5, 32'hFFFF_FFFF);
    doRead(4'd5, 32'h0000_000F, "R12 fsr upper bits zero");
    doWrite(4'd6, 32'h0000_0040);
    doRead(4'd6, 32'h0000_0040, "R12 far software write");

    // R8 cache maintenance table
    doMaint(4'd7, 4'b0111, 3'd0, 6'h30, "R8 flush all caches");
    doMaint(4'd7, 4'b0101, 3'd0, 6'h20, "R8 flush icache");
    doMaint(4'd7, 4'b0110, 3'd0, 6'h10, "R8 flush dcache");
    doMaint(4'd7, 4'b1011, 3'd0, 6'h0C, "R8 clean all");
    doMaint(4'd7, 4'b1010, 3'd0, 6'h04, "R8 clean dcache");
    doMaint(4'd7, 4'b1111, 3'd0, 6'h3C, "R8 clean flush all");
    doMaint(4'd7, 4'b1110, 3'd0, 6'h14, "R8 clean flush dcache");
    // R9 fallbacks
    doMaint(4'd7, 4'b0111, 3'd1, 6'h3C, "R9 nonzero op2");
    doMaint(4'd7, 4'b0000, 3'd0, 6'h3C, "R9 unknown crm");
    // R10 TLB maintenance
    doMaint(4'd8, 4'b0111, 3'd0, 6'h03, "R10 flush all tlbs");
    doMaint(4'd8, 4'b0101, 3'd0, 6'h02, "R10 flush itlb");
    doMaint(4'd8, 4'b0110, 3'd0, 6'h01, "R10 flush dtlb");
    doMaint(4'd8, 4'b0011, 3'd0, 6'h03, "R10 unknown crm");
    doMaint(4'd8, 4'b0101, 3'd2, 6'h03, "R10 nonzero op2");
    doRead(4'd2, 32'hABCD_1234, "R11 maintenance left ttb intact");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R13 all reads returned", 32'(expQ.size()), 32'h0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule